// File: doc/BRIEF.md
# Register-Mapped CRC-16 Check Engine

This block computes a 16-bit frame check value for a low-rate infrared link. Software resets the engine through a control word. It then writes data values one at a time into an input register, and reads the finished check value from an output register. Each accepted value contributes its low byte to a reflected CRC-16: the polynomial is 0x8408 applied LSB first, the register is preset to 0xFFFF, and the result is inverted on read. The control word also shows how many values have been taken since the last reset.

A fixed four-byte vector with a known answer lets driver software test the engine when the link is brought up. The sequence is: reset, write 0xCC, 0xF5, 0xF1, 0xA7, then expect a count of 4 and a check value of 0x51DF.

Inside the engine, a small state machine tracks the fill level of the counter. ENG_RESET means no value has been taken since reset. ENG_ACTIVE means at least one value has been taken and the count is below its ceiling. ENG_FULL means the count has reached 0xFFF. The transitions are:
- CLEAR: from any state to ENG_RESET, on a control write with bit 15 set.
- FIRST: from ENG_RESET to ENG_ACTIVE, on an input write.
- TOP: from ENG_ACTIVE to ENG_FULL, on the input write that brings the count to 0xFFF.
- HOLD: a state stays as it is when there is no write.

Top module: `crc16_engine`

## Requirements
- R1: After hardware reset, the control register reads 0x0000, the output register reads 0x0000 (preset 0xFFFF inverted), and the input register reads 0x0000.
- R2: Each write to the input register folds bits 7:0 of the data into the CRC within one cycle. The fold is reflected: polynomial 0x8408, LSB first, preset 0xFFFF. The output register returns the bitwise inverse of the running CRC at any time.
- R3: After a reset, writing 0xCC, 0xF5, 0xF1, 0xA7 gives a control count of 4 and an output of 0x51DF.
- R4: The input register keeps bits 11:0 of a write and reads them back with bits 15:12 as zero. Bits 11:8 have no effect on the CRC.
- R5: Each input write raises the count in control bits 11:0 by one. Control bits 15:12 always read 0.
- R6: A control write with bit 15 set restores the preset and clears the count. The bit clears itself and reads back as 0. A control write with bit 15 clear changes nothing.
- R7: The count saturates at 0xFFF. Input writes beyond that point still fold into the CRC.
- R8: Read data is registered and appears in the cycle after the read strobe. A read issued in the cycle right after a write returns the updated state.
- R9: The control register is at offset 0x80, the input register at 0x86 and the output register at 0x8E. Any other offset reads 0x0000, and writes to other offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
The assertions assume that the read and write strobes are never raised in the same cycle. They also assume that the address is stable while a strobe is high. The bench issues every access as a single-cycle strobe that it drives on the falling edge, one access at a time, so both assumptions always hold. The input sweeps cover all 256 byte values, upper-nibble variants, and a run of more than 4095 writes.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 8;
    localparam int CNT_W   = 12;
    localparam int IN_W    = 12;
    localparam int BYTE_W  = 8;
    localparam logic [DATA_W-1:0] POLY   = 16'h8408;
    localparam logic [DATA_W-1:0] PRESET = 16'hFFFF;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_IN   = 8'h86;
    localparam logic [ADDR_W-1:0] OFS_OUT  = 8'h8E;
    localparam int CLR_BIT = 15;

    typedef enum logic [1:0] {
        ENG_RESET  = 2'd0,
        ENG_ACTIVE = 2'd1,
        ENG_FULL   = 2'd2
    } eng_state_t;
endpackage

// File: rtl/crc16_fold.sv
module crc16_fold
    import crc16_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int B = BYTE_W,
    parameter logic [W-1:0] P = POLY
) (
    input  logic [W-1:0] crc_in,
    input  logic [B-1:0] byte_in,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] stage [0:B];

    assign stage[0] = crc_in ^ {{(W-B){1'b0}}, byte_in};

    for (genvar i = 0; i < B; i++) begin : g_step
        assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ P) : (stage[i] >> 1);
    end

    assign crc_out = stage[B];
endmodule

// File: rtl/crc16_seq.sv
module crc16_seq
    import crc16_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int CW = CNT_W,
    parameter logic [W-1:0] SEED = PRESET
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          fold,
    input  logic [W-1:0]  crc_next,
    output logic [W-1:0]  crc,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    eng_state_t state_q, state_d;
    logic [W-1:0]  crc_d;
    logic [CW-1:0] cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_RESET;
            crc     <= SEED;
            cnt     <= '0;
        end else begin
            state_q <= state_d;
            crc     <= crc_d;
            cnt     <= cnt_d;
        end
    end

    // next state and datapath outputs
    always_comb begin
        state_d = state_q;
        crc_d   = crc;
        cnt_d   = cnt;
        if (clr) begin
            state_d = ENG_RESET;
            crc_d   = SEED;
            cnt_d   = '0;
        end else if (fold) begin
            crc_d = crc_next;
            unique case (state_q)
                ENG_RESET: begin
                    cnt_d   = cnt + CW'(1);
                    state_d = (cnt_d == CNT_MAX) ? ENG_FULL : ENG_ACTIVE;
                end
                ENG_ACTIVE: begin
                    cnt_d   = cnt + CW'(1);
                    state_d = (cnt_d == CNT_MAX) ? ENG_FULL : ENG_ACTIVE;
                end
                ENG_FULL: begin
                    cnt_d   = cnt;
                    state_d = ENG_FULL;
                end
                default: state_d = ENG_RESET;
            endcase
        end
    end

    // R5
    // cnt_step_chk
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fold && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + CW'(1));

    // R7
    // sat_hold_chk
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

    // R6
    // clear_effect_chk
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && crc == SEED));

    // R5
    // idle_hold_chk
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !fold) |=> ($stable(cnt) && $stable(crc)));
endmodule

// File: rtl/crc16_regs.sv
module crc16_regs
    import crc16_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int IW = IN_W,
    parameter int B  = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  crc,
    input  logic [CW-1:0] cnt,
    output logic          clr,
    output logic          fold,
    output logic [B-1:0]  fold_byte,
    output logic [W-1:0]  bus_rdata
);
    logic [IW-1:0] in_q;
    logic [W-1:0]  rd_mux;
    logic          wdata_unused;

    assign wdata_unused = ^bus_wdata[W-2:IW];
    assign clr       = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[CLR_BIT];
    assign fold      = bus_wr && (bus_addr == OFS_IN);
    assign fold_byte = bus_wdata[B-1:0];

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL: rd_mux = {{(W-CW){1'b0}}, cnt};
            OFS_IN:   rd_mux = {{(W-IW){1'b0}}, in_q};
            OFS_OUT:  rd_mux = ~crc;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q      <= '0;
            bus_rdata <= '0;
        end else begin
            if (fold) in_q <= bus_wdata[IW-1:0];
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end

    // R6
    // clr_readback_chk
    clr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_CTRL) |=> bus_rdata[W-1:CW] == '0);

    // R8
    // rdata_hold_chk
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R4
    // in_upper_chk
    in_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_IN) |=> bus_rdata[W-1:IW] == '0);
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
    import crc16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              clr, fold;
    logic [BYTE_W-1:0] fold_byte;
    logic [DATA_W-1:0] crc, crc_next;
    logic [CNT_W-1:0]  cnt;

    crc16_regs #(.W(DATA_W), .AW(ADDR_W), .CW(CNT_W), .IW(IN_W), .B(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .crc(crc), .cnt(cnt),
        .clr(clr), .fold(fold), .fold_byte(fold_byte), .bus_rdata(bus_rdata)
    );

    crc16_fold #(.W(DATA_W), .B(BYTE_W), .P(POLY)) u_fold (
        .crc_in(crc), .byte_in(fold_byte), .crc_out(crc_next)
    );

    crc16_seq #(.W(DATA_W), .CW(CNT_W), .SEED(PRESET)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fold(fold),
        .crc_next(crc_next), .crc(crc), .cnt(cnt)
    );
endmodule

// File: tb/test_crc16_engine.sv
module test_crc16_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [15:0] ref_crc;
    logic [15:0] rv;

    always #2.5 clk = ~clk;

    crc16_engine i_crc16_engine (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] x = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) x = x[0] ? ((x >> 1) ^ 16'h8408) : (x >> 1);
        return x;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h80, rv); check("R1 ctrl", rv, 16'h0000);
        rd(8'h8E, rv); check("R1 out", rv, 16'h0000);
        rd(8'h86, rv); check("R1 in", rv, 16'h0000);

        // R3 self-test vector
        wr(8'h80, 16'h8000);
        wr(8'h86, 16'h00CC); wr(8'h86, 16'h00F5);
        wr(8'h86, 16'h00F1); wr(8'h86, 16'h00A7);
        rd(8'h80, rv); check("R3 count", rv, 16'h0004);
        rd(8'h8E, rv); check("R3 out", rv, 16'h51DF);

        // R6 control write without bit 15 has no effect; R9 unmapped write ignored
        wr(8'h80, 16'h7FFF);
        wr(8'h84, 16'h80AA);
        rd(8'h80, rv); check("R6 no-clear count", rv, 16'h0004);
        rd(8'h8E, rv); check("R9 unmapped write out", rv, 16'h51DF);
        rd(8'h84, rv); check("R9 unmapped read", rv, 16'h0000);

        // R6 clear restores preset, bit reads 0
        wr(8'h80, 16'hFFFF);
        rd(8'h80, rv); check("R6 ctrl after clear", rv, 16'h0000);
        rd(8'h8E, rv); check("R6 out after clear", rv, 16'h0000);

        // R2 R5 sweep of all byte values, R8 read right after each write
        ref_crc = 16'hFFFF;
        for (int i = 0; i < 256; i++) begin
            wr(8'h86, 16'(i));
            ref_crc = ref_fold(ref_crc, 8'(i));
            rd(8'h8E, rv); check("R2 R8 sweep out", rv, ~ref_crc);
            rd(8'h80, rv); check("R5 sweep count", rv, 16'(i + 1));
        end

        // R4 upper bits stored, 11:8 no effect on CRC
        for (int h = 0; h < 16; h++) begin
            wr(8'h80, 16'h8000);
            wr(8'h86, {4'hA, 4'(h), 8'h3C});
            rd(8'h86, rv); check("R4 readback", rv, {4'h0, 4'(h), 8'h3C});
            rd(8'h8E, rv); check("R4 crc ignores 11:8", rv, ~ref_fold(16'hFFFF, 8'h3C));
        end

        // R7 saturation
        wr(8'h80, 16'h8000);
        ref_crc = 16'hFFFF;
        for (int i = 0; i < 4100; i++) begin
            wr(8'h86, 16'(i * 7));
            ref_crc = ref_fold(ref_crc, 8'(i * 7));
            if (i == 4093 || i == 4094 || i == 4099) begin
                rd(8'h80, rv);
                check("R7 count", rv, (i >= 4094) ? 16'h0FFF : 16'(i + 1));
            end
        end
        rd(8'h8E, rv); check("R7 fold past ceiling", rv, ~ref_crc);

        summary();
    end
endmodule